// File: doc/BRIEF.md
# Nested loop index generator

This block steps through the iteration space of a perfect loop nest in hardware. It holds one index register for each nesting level. Each index starts at zero and moves forward by that level's stride. It never reaches that level's bound, in the same way as a C `for` loop with a strict less-than test. A datapath that runs the body of the innermost loop raises a one-bit handshake when it has finished the current iteration. On the next clock edge the block loads the next iteration tuple.

Every update, including one where several levels wrap at the same time, takes exactly one clock cycle. The nest therefore costs no control cycles beyond the body itself. When the whole iteration space has been covered, all indices return to zero and a completion flag rises. The flag stays high until reset.

Bounds, strides and indices are packed vectors with one DW-bit field per level. The number of levels is NLP.

Top module: `loop_nest_indexer`

## Requirements
- R1: Level k, counted 1 to NLP, occupies bits k*DW-1 down to (k-1)*DW of `bound_i`, `stride_i` and `idx_o`. Level 1 is the outermost level and level NLP is the innermost.
- R2: While `rst` is high at a clock edge, every index is cleared to zero and `done_o` is cleared.
- R3: At an edge where `body_done` is low, `idx_o` and `done_o` keep their values.
- R4: At an edge where `body_done` is high and `done_o` is low, the block selects the innermost level whose index plus stride is below its bound. That level advances by its stride, every level inside it is set to zero, and every level outside it keeps its value.
- R5: If the innermost level's index plus stride is below its bound, only the innermost level changes, and it advances by its stride.
- R6: If no level's index plus stride is below its bound, all indices become zero and `done_o` rises on that same edge.
- R7: Once `done_o` is high, it stays high and all indices stay at zero until reset, whatever `body_done` does.
- R8: The index-plus-stride test is made at DW+1 bits. A sum that overflows DW bits is treated as reaching the bound and never as being below it.
- R9: When several inner levels wrap together, all of them are zeroed and the enclosing level advances, all in one cycle.
- R10: With NLP=3, DW=4, bounds 4, 7, 4 and strides 3, 1, 2 (outer to inner), the nest yields 28 distinct tuples. `done_o` rises on the 28th handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| body_done | input | 1 | Innermost body finished; step to the next tuple |
| bound_i | input | NLP*DW | Packed loop bounds (exclusive) |
| stride_i | input | NLP*DW | Packed loop strides |
| idx_o | output | NLP*DW | Packed current iteration tuple |
| done_o | output | 1 | Whole nest completed (sticky) |

## Verification
The worked three-level nest is run with the handshake held high the whole time. It checks every tuple in lexicographic order, including the edges where two levels wrap together, and that completion comes on exactly the 28th step. A directed case with inner bound 15 and stride 12 overflows the four-bit field. It separates a DW+1-bit comparison from a truncated one, because a truncated sum would let the inner level step a second time. Random bounds, strides and handshake gaps, compared each cycle against a bench model, probe hold behaviour, single-level strides, and bounds smaller than or equal to the stride. After completion the handshake keeps toggling, to show that the indices stay at zero and the flag stays high.

// File: rtl/loop_nest_indexer.sv
module loop_nest_indexer #(
  parameter int NLP = 3,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              body_done,
  input  logic [NLP*DW-1:0] bound_i,
  input  logic [NLP*DW-1:0] stride_i,
  output logic [NLP*DW-1:0] idx_o,
  output logic              done_o
);
  localparam int W  = NLP * DW;
  localparam int SW = DW + 1;

  logic [W-1:0]      idx_q, idx_d;
  logic              done_q;
  logic [NLP*SW-1:0] sums;
  logic [NLP-1:0]    fits;
  logic [NLP:0]      any_in;

  assign any_in[NLP] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < NLP; g++) begin : lvl
      assign sums[g*SW +: SW] = {1'b0, idx_q[g*DW +: DW]} + {1'b0, stride_i[g*DW +: DW]};
      assign fits[g]          = sums[g*SW +: SW] < {1'b0, bound_i[g*DW +: DW]};
      assign any_in[g]        = |fits[NLP-1:g];
      assign idx_d[g*DW +: DW] = !any_in[g]                ? '0 :
                                 (fits[g] && !any_in[g+1]) ? sums[g*SW +: DW] :
                                                             idx_q[g*DW +: DW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (body_done && !done_q) begin
      idx_q <= idx_d;
      if (!any_in[0]) done_q <= 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign done_o = done_q;
endmodule

// File: rtl/loop_nest_indexer_chk.sv
module loop_nest_indexer_chk #(
  parameter int NLP = 3,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              body_done,
  input logic [NLP*DW-1:0] bound_i,
  input logic [NLP*DW-1:0] stride_i,
  input logic [NLP*DW-1:0] idx_o,
  input logic              done_o
);
  localparam int W = NLP * DW;

  // R2
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (idx_o == '0 && !done_o));

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !body_done |=> ($stable(idx_o) && $stable(done_o)));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);

  // R7
  done_zero_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> idx_o == '0);

  // R5
  inner_step_chk: assert property (@(posedge clk) disable iff (rst)
    (body_done && !done_o &&
     ({1'b0, idx_o[W-1 -: DW]} + {1'b0, stride_i[W-1 -: DW]} < {1'b0, bound_i[W-1 -: DW]}))
    |=> idx_o[W-1 -: DW] == $past(idx_o[W-1 -: DW] + stride_i[W-1 -: DW]));

  // R4
  outer_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(idx_o[DW-1:0] != '0) |-> idx_o[W-1:DW] == '0);
endmodule

bind loop_nest_indexer loop_nest_indexer_chk #(.NLP(NLP), .DW(DW)) u_chk (.*);

// File: tb/tb_loop_nest_indexer.sv
`timescale 1ns/1ps
module tb_loop_nest_indexer;
  localparam int NLP = 3;
  localparam int DW  = 4;
  localparam int W   = NLP * DW;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         body_done = 1'b0;
  logic [W-1:0] bound_i = '0;
  logic [W-1:0] stride_i = '0;
  logic [W-1:0] idx_o;
  logic         done_o;

  logic [W-1:0] exp_idx;
  bit           exp_done;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           finished = 0;

  always #2.5 clk = ~clk;

  loop_nest_indexer #(.NLP(NLP), .DW(DW)) dut (.*);

  function automatic void model(input logic [W-1:0] b, input logic [W-1:0] s,
                                inout logic [W-1:0] ix, inout bit dn);
    bit found = 0;
    for (int k = NLP - 1; k >= 0; k--) begin
      if (!found) begin
        int sum = int'(ix[k*DW +: DW]) + int'(s[k*DW +: DW]);
        if (sum < int'(b[k*DW +: DW])) begin
          ix[k*DW +: DW] = sum[DW-1:0];
          found = 1;
        end else begin
          ix[k*DW +: DW] = '0;
        end
      end
    end
    if (!found) dn = 1;
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input bit a, input string req);
    body_done = a;
    if (a && !exp_done) model(bound_i, stride_i, exp_idx, exp_done);
    @(posedge clk); #1;
    check(req, {done_o, idx_o}, {exp_done, exp_idx});
  endtask

  task automatic do_reset();
    rst = 1'b1; body_done = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
    exp_idx = '0; exp_done = 0;
  endtask

  initial begin
    int steps;
    void'($urandom(32'd1234));
    exp_idx = '0; exp_done = 0;
    @(posedge clk); #1;
    do_reset();
    // R2: reset state
    check("R2", {done_o, idx_o}, '0);

    // R10 / R1: bounds 4,7,4 strides 3,1,2, level 1 in low bits
    bound_i  = {4'd4, 4'd7, 4'd4};
    stride_i = {4'd2, 4'd1, 4'd3};
    steps = 0;
    while (!exp_done && steps < 100) begin
      steps++;
      // R9 covered where middle and inner wrap together
      cycle(1'b1, "R4/R9/R1");
    end
    check("R10", W'(steps), W'(28));
    // R7: handshake keeps toggling after completion
    for (int i = 0; i < 10; i++) cycle(i % 2 == 0, "R7");
    check("R7", {done_o, idx_o}, {1'b1, {W{1'b0}}});

    // R3: hold while handshake low
    do_reset();
    cycle(1'b1, "R5");
    check("R5", idx_o, {4'd2, 4'd0, 4'd0});
    for (int i = 0; i < 4; i++) cycle(1'b0, "R3");
    check("R3", idx_o, {4'd2, 4'd0, 4'd0});

    // R8: inner bound 15 stride 12 overflows four bits on the second step
    bound_i  = {4'd15, 4'd3, 4'd2};
    stride_i = {4'd12, 4'd1, 4'd1};
    do_reset();
    cycle(1'b1, "R8");
    check("R8", idx_o, {4'd12, 4'd0, 4'd0});
    cycle(1'b1, "R8");
    check("R8", idx_o, {4'd0, 4'd1, 4'd0});

    // R6: every level already at its last value
    bound_i  = {4'd1, 4'd1, 4'd1};
    stride_i = {4'd1, 4'd1, 4'd1};
    do_reset();
    cycle(1'b1, "R6");
    check("R6", {done_o, idx_o}, {1'b1, {W{1'b0}}});

    // random nests with handshake gaps
    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < NLP; k++) begin
        bound_i[k*DW +: DW]  = DW'($urandom_range(1, 15));
        stride_i[k*DW +: DW] = DW'($urandom_range(1, 15));
      end
      do_reset();
      for (int c = 0; c < 600 && !exp_done; c++)
        cycle($urandom_range(0, 9) < 7, "R4/R3/R6");
      for (int c = 0; c < 3; c++) cycle(1'b1, "R7");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule